// File: doc/BRIEF.md
# UART Transmit Echo Error Checker

This block checks a UART transmitter while it runs. The remote station sends back every bit it receives. The block compares each returned bit with a copy of the bit that was sent, delayed by one or two bit times to cover the loop delay. Nothing has to be done per byte by a processor. The block does not need to know the character in advance: it sees each transmitted bit at the bit-time strobe and infers the frame from the start bit.

A transmitter framer tags every transmitted bit with its place in the character: start, data, parity or stop. The tag moves through a short delay line of two stages. The stage the delay select picks is compared with the echo line on each bit-time strobe, which the baud logic places at the mid-bit sample point. The first mismatch sets a sticky error flag, stores the position of the bit in error, and pulses the interrupt output. The flag and position stay until software clears them. Idle-line bits and anything seen while the block is disabled are not compared.

Top module: `echo_tx_checker`

## Requirements
- R1: After reset, err_flag is 0, err_pos is 0 and irq is 0.
- R2: With dly_sel=0, the echo sampled at a strobe is compared with the transmitted bit sampled at the previous strobe, so an echo returned one bit time late raises no error.
- R3: With dly_sel=1, the echo is compared with the transmitted bit from two strobes earlier, so an echo returned two bit times late raises no error and an echo returned one bit time late is flagged.
- R4: A mismatch at a strobe sets err_flag on the next clock edge and pulses irq high for exactly that one clock.
- R5: err_pos encodes the failing bit as 0 for the start bit, 1 to 8 for data bits 0 to 7, 9 for parity and 10 for the stop bit (defaults DATA_BITS=8, PARITY_EN=1). A frame begins when a 0 is transmitted while no frame is in progress.
- R6: Once err_flag is set, later mismatches change neither err_flag nor err_pos and raise no further irq until a clear.
- R7: clr drives err_flag and err_pos to 0 on the next edge. It takes priority over a mismatch in the same cycle, and that mismatch is discarded.
- R8: Bits sent while no frame is in progress (idle line) are never compared, so echo values against them raise no error.
- R9: While en is 0, no comparison happens, and the frame tracking and delay line are emptied.
- R10: The echo line is compared only in cycles where bit_stb is 1. Echo values between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Checker enable |
| bit_stb | input | 1 | One-cycle strobe at the mid-bit sample point of each bit time |
| tx_bit | input | 1 | Bit being transmitted, valid with bit_stb |
| echo_bit | input | 1 | Echoed receive line, sampled with bit_stb |
| dly_sel | input | 1 | Compare delay: 0 = one bit time, 1 = two bit times |
| clr | input | 1 | Clears the error flag and the stored position |
| err_flag | output | 1 | Sticky error flag |
| err_pos | output | 4 | Position of the first failing bit in the character |
| irq | output | 1 | One-cycle interrupt pulse on the first error |

## Verification
The assertions check the rules that hold on every cycle. The flag only changes on a strobe or a clear. It stays quiet while disabled. A set flag keeps its position. irq pulses exactly when the flag rises, and a clear always wins. Whether the right tap is compared, whether positions are numbered correctly from the start bit, and whether idle bits are ignored can only be shown by the bench. The bench sends whole characters with chosen echo delays, corrupted echo bits and clear timing, and compares the outcome with its own frame model.

// File: rtl/echo_chk_pkg.sv
package echo_chk_pkg;
    localparam int POS_W = 4;

    typedef struct packed {
        logic             vld;
        logic [POS_W-1:0] pos;
        logic             bitv;
    } bit_tag_t;
endpackage

// File: rtl/echo_framer.sv
module echo_framer
    import echo_chk_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int PARITY_EN = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     stb,
    input  logic     tx_bit,
    output bit_tag_t tag_o
);
    localparam int LAST_POS = DATA_BITS + PARITY_EN + 1;

    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] pos;
    } frm_state_t;

    frm_state_t st_d, st_q;
    bit_tag_t   tag_d;

    always_comb begin
        st_d       = st_q;
        tag_d      = '0;
        tag_d.bitv = tx_bit;
        if (!en) begin
            st_d = '0;
        end else if (stb) begin
            if (!st_q.active) begin
                if (!tx_bit) begin
                    tag_d.vld   = 1'b1;
                    tag_d.pos   = '0;
                    st_d.active = 1'b1;
                    st_d.pos    = POS_W'(1);
                end
            end else begin
                tag_d.vld = 1'b1;
                tag_d.pos = st_q.pos;
                if (st_q.pos == POS_W'(LAST_POS)) begin
                    st_d = '0;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_o = tag_d;
endmodule

// File: rtl/echo_delay_line.sv
module echo_delay_line
    import echo_chk_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stb,
    input  bit_tag_t         tag_i,
    input  logic [SEL_W-1:0] sel,
    output bit_tag_t         tap_o
);
    typedef struct packed {
        bit_tag_t [STAGES-1:0] stg;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (stb) begin
            st_d.stg[0] = tag_i;
            for (int i = 1; i < STAGES; i++) begin
                st_d.stg[i] = st_q.stg[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_o = st_q.stg[sel];
endmodule

// File: rtl/echo_err_capture.sv
module echo_err_capture
    import echo_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stb,
    input  logic             echo_bit,
    input  bit_tag_t         tap_i,
    input  logic             clr,
    output logic             err_o,
    output logic [POS_W-1:0] pos_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             err;
        logic [POS_W-1:0] pos;
        logic             irq;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       miss;

    always_comb begin
        miss     = stb && en && tap_i.vld && (tap_i.bitv != echo_bit);
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (clr) begin
            st_d.err = 1'b0;
            st_d.pos = '0;
        end else if (miss && !st_q.err) begin
            st_d.err = 1'b1;
            st_d.pos = tap_i.pos;
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;
    assign pos_o = st_q.pos;
    assign irq_o = st_q.irq;
endmodule

// File: rtl/echo_tx_checker.sv
module echo_tx_checker
    import echo_chk_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int PARITY_EN  = 1,
    parameter int DLY_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_stb,
    input  logic             tx_bit,
    input  logic             echo_bit,
    input  logic             dly_sel,
    input  logic             clr,
    output logic             err_flag,
    output logic [POS_W-1:0] err_pos,
    output logic             irq
);
    localparam int SEL_W = (DLY_STAGES > 1) ? $clog2(DLY_STAGES) : 1;

    bit_tag_t cur_tag;
    bit_tag_t tap_tag;

    echo_framer #(
        .DATA_BITS(DATA_BITS),
        .PARITY_EN(PARITY_EN)
    ) framer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .stb    (bit_stb),
        .tx_bit (tx_bit),
        .tag_o  (cur_tag)
    );

    echo_delay_line #(
        .STAGES(DLY_STAGES)
    ) dline_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .stb    (bit_stb),
        .tag_i  (cur_tag),
        .sel    (SEL_W'(dly_sel)),
        .tap_o  (tap_tag)
    );

    echo_err_capture cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .stb      (bit_stb),
        .echo_bit (echo_bit),
        .tap_i    (tap_tag),
        .clr      (clr),
        .err_o    (err_flag),
        .pos_o    (err_pos),
        .irq_o    (irq)
    );
endmodule

// File: rtl/echo_tx_checker_sva.sv
module echo_tx_checker_sva
    import echo_chk_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int PARITY_EN = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             bit_stb,
    input logic             clr,
    input logic             err_flag,
    input logic [POS_W-1:0] err_pos,
    input logic             irq
);
    localparam int LAST_POS = DATA_BITS + PARITY_EN + 1;

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!err_flag && err_pos == '0));

    a_r6_first_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> (err_flag && $stable(err_pos)));

    a_r4_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (err_flag && !$past(err_flag)));

    a_r4_rise_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> irq);

    a_r10_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !err_flag) |=> !err_flag);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !err_flag) |=> !err_flag);

    a_r5_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (err_pos <= POS_W'(LAST_POS)));
endmodule

bind echo_tx_checker echo_tx_checker_sva #(
    .DATA_BITS(DATA_BITS),
    .PARITY_EN(PARITY_EN)
) sva_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .bit_stb  (bit_stb),
    .clr      (clr),
    .err_flag (err_flag),
    .err_pos  (err_pos),
    .irq      (irq)
);

// File: tb/echo_tx_checker_tb_top.sv
module echo_tx_checker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       bit_stb = 1'b0;
    logic       tx_bit = 1'b1;
    logic       echo_bit = 1'b1;
    logic       dly_sel = 1'b0;
    logic       clr = 1'b0;
    logic       err_flag;
    logic [3:0] err_pos;
    logic       irq;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;

    always #2 clk = ~clk;

    echo_tx_checker dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_stb(bit_stb),
        .tx_bit(tx_bit), .echo_bit(echo_bit), .dly_sel(dly_sel), .clr(clr),
        .err_flag(err_flag), .err_pos(err_pos), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe cycle; the echo line is inverted in the cycle after (R10).
    task automatic strobe(input logic tx, input logic ec, input logic cl);
        @(negedge clk);
        bit_stb = 1'b1; tx_bit = tx; echo_bit = ec; clr = cl;
        @(negedge clk);
        bit_stb = 1'b0; clr = 1'b0; echo_bit = ~ec; tx_bit = 1'b1;
        @(negedge clk);
        echo_bit = 1'b1;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        irq_cnt = 0;
    endtask

    function automatic logic [10:0] build_frame(input logic [7:0] d);
        return {1'b1, ^d, d, 1'b0};
    endfunction

    // 18 strobes: 2 idle, 11 frame bits, 5 idle. Expected results come from a bench model.
    task automatic run_frame(input logic [7:0] data, input int sel_d, input int echo_d,
                             input logic [17:0] flip, input bit en_v, input int clr_k,
                             input string req);
        logic [10:0] fb;
        bit exp_err;
        int exp_pos;
        int exp_irq;
        fb = build_frame(data);
        do_clear();
        exp_err = 0; exp_pos = 0; exp_irq = 0;
        en = en_v;
        dly_sel = (sel_d == 2);
        for (int k = 0; k < 18; k++) begin
            int fi;
            int src;
            int p;
            logic txv;
            logic ecv;
            fi  = k - 2;
            txv = (fi >= 0 && fi <= 10) ? fb[fi] : 1'b1;
            src = fi - echo_d;
            ecv = (src >= 0 && src <= 10) ? fb[src] : 1'b1;
            if (flip[k]) ecv = ~ecv;
            p = fi - sel_d;
            if (k == clr_k) begin
                exp_err = 0; exp_pos = 0;
            end else if (en_v && p >= 0 && p <= 10 && ecv != fb[p] && !exp_err) begin
                exp_err = 1; exp_pos = p; exp_irq++;
            end
            strobe(txv, ecv, k == clr_k);
        end
        chk(err_flag == exp_err, req, int'(err_flag), int'(exp_err));
        chk(int'(err_pos) == exp_pos, req, int'(err_pos), exp_pos);
        chk(irq_cnt == exp_irq, req, irq_cnt, exp_irq);
        en = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!err_flag, "R1", int'(err_flag), 0);
        chk(err_pos == 4'd0, "R1", int'(err_pos), 0);
        chk(!irq, "R1", int'(irq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R3: clean echoes at the matching delay
        run_frame(8'hA5, 1, 1, '0, 1, -1, "R2");
        run_frame(8'h00, 1, 1, '0, 1, -1, "R2");
        run_frame(8'h3C, 2, 2, '0, 1, -1, "R3");
        run_frame(8'hFF, 2, 2, '0, 1, -1, "R3");
        // R3: one-bit-late echo with the two-bit tap selected is flagged
        run_frame(8'h01, 2, 1, '0, 1, -1, "R3");
        // R4 / R5: single corrupted bit at every position, both delays
        for (int p = 0; p <= 10; p++) begin
            for (int s = 1; s <= 2; s++) begin
                logic [17:0] m;
                m = '0;
                m[2 + p + s] = 1'b1;
                run_frame(8'($urandom), s, s, m, 1, -1, (p == 0) ? "R4" : "R5");
            end
        end
        // R6: two corruptions, the first one is kept
        run_frame(8'h5A, 1, 1, 18'h1 << (2 + 2 + 1) | 18'h1 << (2 + 7 + 1), 1, -1, "R6");
        run_frame(8'hC3, 2, 2, 18'h1 << (2 + 4 + 2) | 18'h1 << (2 + 10 + 2), 1, -1, "R6");
        // R8: corruption only on idle strobes
        run_frame(8'h77, 1, 1, 18'b11_0000_0000_0000_0011, 1, -1, "R8");
        run_frame(8'h77, 2, 2, 18'b11_0000_0000_0000_0111, 1, -1, "R8");
        // R9: disabled, corruptions everywhere
        run_frame(8'h96, 1, 1, 18'h3FFFF, 0, -1, "R9");
        // R7: clear in the same cycle as the only mismatch
        run_frame(8'h42, 1, 1, 18'h1 << (2 + 3 + 1), 1, 2 + 3 + 1, "R7");
        // R7: clear after an error has been taken
        run_frame(8'h42, 1, 1, 18'h1 << (2 + 5 + 1), 1, -1, "R7");
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(!err_flag, "R7", int'(err_flag), 0);
        chk(err_pos == 4'd0, "R7", int'(err_pos), 0);
        // Random mix
        for (int n = 0; n < 150; n++) begin
            logic [17:0] m;
            int s;
            s = ($urandom % 2) + 1;
            m = '0;
            for (int b = 0; b < 18; b++) m[b] = (($urandom % 12) == 0);
            run_frame(8'($urandom), s, s, m, ($urandom % 8) != 0,
                      (($urandom % 6) == 0) ? int'($urandom % 18) : -1, "R5");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule